// File: doc/BRIEF.md
# Standby Mode Clock Controller

This block sits beside a CPU core and owns its low-power standby state. The core raises a one-cycle strobe when it executes a halt instruction or a sleep instruction. The block then gates the matching clock enables. These cover the CPU clock, the external bus and DMA clock, the high-speed oscillator and the peripheral clock. The low-speed oscillator and the clock-timer enables are never gated. A configuration input selects between a shallow halt, which stops only the CPU, and a deep halt, which also stops the bus and DMA clock. Sleep is the deepest level and also stops the high-speed oscillator and the peripherals.

Each standby level has its own set of wake sources. Either halt level wakes on NMI or on any interrupt. Sleep wakes only on NMI, the clock-timer interrupt or an external interrupt. Peripheral interrupts cannot wake sleep, because those peripherals run from the stopped oscillator. When the core's interrupt-enable flag is clear, only NMI and reset can wake any level. An interrupt wake gives the core a one-cycle trap request and the address captured at entry, which is the address of the instruction after the standby instruction. Leaving sleep passes through a settle phase. In that phase the oscillator runs but the CPU clock stays off for a fixed number of low-speed clock ticks.

Top module: `stby_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `stby_state` is RUN. `cpu_clk_en`, `bus_clk_en`, `hosc_en`, `losc_en` and `ctm_en` are 1, `per_clk_en` equals `per_clk_req`, and `trap_req` is 0. The state encoding is RUN=0, HALT=1, DEEP HALT=2, SLEEP=3, SETTLE=4.
- R2: A `halt_req` strobe in RUN with `cfg_deep_halt`=0 enters HALT on the next cycle. In HALT `cpu_clk_en`=0 and `bus_clk_en`=1 and `hosc_en`=1.
- R3: A `halt_req` strobe in RUN with `cfg_deep_halt`=1 enters DEEP HALT. In DEEP HALT `cpu_clk_en`=0, `bus_clk_en`=0 and `hosc_en`=1.
- R4: In either halt level, `per_clk_en` holds the value that `per_clk_req` had in the cycle of the strobe, whatever `per_clk_req` does afterwards.
- R5: A `sleep_req` strobe in RUN enters SLEEP. In SLEEP `cpu_clk_en`, `bus_clk_en`, `hosc_en` and `per_clk_en` are 0. `losc_en` and `ctm_en` stay 1 in every state.
- R6: With `int_en`=1, either halt level returns to RUN on NMI, the clock-timer interrupt, any external interrupt bit or any peripheral interrupt bit.
- R7: SLEEP ends only on NMI, or on the clock-timer interrupt or an external interrupt while `int_en`=1. Peripheral interrupt bits leave SLEEP unchanged.
- R8: With `int_en`=0, no maskable interrupt ends any standby level, and NMI still does.
- R9: Every interrupt wake raises `trap_req` for exactly one cycle, in the cycle RUN resumes. From entry until the next entry, `ret_addr` holds the `next_pc` value sampled with the entry strobe.
- R10: A sleep wake first enters SETTLE, where `hosc_en`=1 and `cpu_clk_en`=0. The block returns to RUN on the SETTLE_CYCLES-th `lsc_tick` counted in SETTLE, and cycles without a tick do not count.
- R11: Reset overrides every state and every simultaneous wake source. The next cycle is RUN with `trap_req`=0.
- R12: Entry strobes are acted on only in RUN. A wake condition for the requested level in the strobe's cycle cancels the entry, so the block stays in RUN. `sleep_req` wins over `halt_req` when both are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Synchronous active-low reset, also a wake source |
| halt_req | input | 1 | Halt instruction strobe from the core |
| sleep_req | input | 1 | Sleep instruction strobe from the core |
| cfg_deep_halt | input | 1 | 0 selects shallow halt, 1 selects deep halt |
| int_en | input | 1 | Interrupt-enable flag of the core status register |
| nmi | input | 1 | Non-maskable interrupt |
| ctm_irq | input | 1 | Clock-timer interrupt |
| ext_irq | input | NEXT | External interrupt lines |
| per_irq | input | NPER | Interrupts from high-speed-clocked peripherals |
| per_clk_req | input | 1 | Peripheral clock enable wanted while running |
| next_pc | input | AW | Address of the instruction after the strobed one |
| lsc_tick | input | 1 | One-cycle pulse per low-speed clock period |
| cpu_clk_en | output | 1 | CPU clock enable |
| bus_clk_en | output | 1 | External bus and DMA clock enable |
| hosc_en | output | 1 | High-speed oscillator enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| losc_en | output | 1 | Low-speed oscillator enable |
| ctm_en | output | 1 | Clock-timer enable |
| trap_req | output | 1 | One-cycle trap request on interrupt wake |
| ret_addr | output | AW | Return address captured at entry |
| stby_state | output | 3 | Current state encoding |

## Verification
The embedded properties check several rules on every cycle: no direct jump between standby levels, the sleep masking of peripheral and maskable sources, the one-cycle trap pulse, the frozen return address and held peripheral enable during standby, and the settle counter's range and hold behaviour. The exact tick at which SETTLE releases the CPU clock, cancellation of an entry by a wake in the same cycle, and the gate pattern of each level can only be shown by the bench scenarios. Those scenarios compare every output cycle by cycle against a bench model under directed and seeded random traffic.

// File: rtl/stby_pkg.sv
// Package: shared state type and helpers for the standby controller.
// Assumes: the state encoding is visible on the stby_state port.
package stby_pkg;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_HALT      = 3'd1,
        ST_HALT_DEEP = 3'd2,
        ST_SLEEP     = 3'd3,
        ST_SETTLE    = 3'd4
    } stby_state_e;

    // True for either halt level.
    function automatic logic is_halt(input stby_state_e s);
        return (s == ST_HALT) || (s == ST_HALT_DEEP);
    endfunction

endpackage

// File: rtl/stby_wake_qual.sv
// Wake qualifier: reduces raw interrupt lines to one wake flag per standby depth.
// Assumes: all lines are synchronous to clk and level-sensitive.
module stby_wake_qual #(
    parameter int NEXT = 4,
    parameter int NPER = 8
) (
    input  logic            int_en,
    input  logic            nmi,
    input  logic            ctm_irq,
    input  logic [NEXT-1:0] ext_irq,
    input  logic [NPER-1:0] per_irq,
    output logic            wake_halt,
    output logic            wake_sleep
);

    logic ext_any;
    logic per_any;
    logic low_clk_src;

    // Reduce the source vectors.
    always_comb begin
        ext_any = |ext_irq;
        per_any = |per_irq;
    end

    // Sources that keep running with the high-speed oscillator stopped.
    always_comb low_clk_src = ctm_irq | ext_any;

    // Halt accepts every source; sleep only the low-speed-clocked ones.
    always_comb begin
        wake_halt  = nmi | (int_en & (low_clk_src | per_any));
        wake_sleep = nmi | (int_en & low_clk_src);
    end

    // R7: any source that can wake sleep must also wake halt.
    always_comb begin
        a_sleep_subset_r7: assert (!wake_sleep || wake_halt);
    end

endmodule

// File: rtl/stby_settle_cnt.sv
// Settle counter: counts low-speed ticks after a sleep wake until the oscillator is usable.
// Assumes: clr pulses on SETTLE entry; en is high only in SETTLE.
module stby_settle_cnt #(
    parameter int SETTLE_CYCLES = 16,
    localparam int CW = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic tick,
    output logic done
);

    localparam logic [CW-1:0] LAST = CW'(SETTLE_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Last tick of the window releases the CPU clock.
    always_comb done = en & tick & (cnt_q == LAST);

    // Tick counter, cleared on entry and at the end of the window.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (en && tick) begin
            cnt_q <= done ? '0 : cnt_q + 1'b1;
        end
    end

    p_cnt_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    p_cnt_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !tick && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/stby_clk_dec.sv
// Clock-enable decoder: maps the controller state to the gate enables and holds
// the peripheral enable captured at halt entry.
// Assumes: capture pulses in the cycle an entry strobe is accepted.
module stby_clk_dec
    import stby_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  stby_state_e state,
    input  logic        capture,
    input  logic        per_clk_req,
    output logic        cpu_clk_en,
    output logic        bus_clk_en,
    output logic        hosc_en,
    output logic        per_clk_en,
    output logic        losc_en,
    output logic        ctm_en
);

    logic per_hold_q;

    // Latch the running peripheral enable at standby entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_hold_q <= 1'b1;
        end else if (capture) begin
            per_hold_q <= per_clk_req;
        end
    end

    // Gate pattern per state.
    always_comb begin
        cpu_clk_en = 1'b0;
        bus_clk_en = 1'b0;
        hosc_en    = 1'b0;
        per_clk_en = 1'b0;
        unique case (state)
            ST_RUN: begin
                cpu_clk_en = 1'b1;
                bus_clk_en = 1'b1;
                hosc_en    = 1'b1;
                per_clk_en = per_clk_req;
            end
            ST_HALT: begin
                bus_clk_en = 1'b1;
                hosc_en    = 1'b1;
                per_clk_en = per_hold_q;
            end
            ST_HALT_DEEP: begin
                hosc_en    = 1'b1;
                per_clk_en = per_hold_q;
            end
            ST_SETTLE: begin
                hosc_en    = 1'b1;
            end
            default: ;
        endcase
    end

    // Low-speed domain is never gated.
    always_comb begin
        losc_en = 1'b1;
        ctm_en  = 1'b1;
    end

    p_halt_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_halt(state) && !capture) |=> (!is_halt(state) || $stable(per_clk_en)));

endmodule

// File: rtl/stby_ctrl.sv
// Standby controller top: sequences RUN, the two halt levels, SLEEP and the
// oscillator settle phase, and issues the wake trap with its return address.
// Assumes: halt_req/sleep_req are single-cycle strobes from the core; next_pc is
// valid with them; lsc_tick is a one-cycle pulse per low-speed period.
module stby_ctrl
    import stby_pkg::*;
#(
    parameter int NEXT          = 4,
    parameter int NPER          = 8,
    parameter int AW            = 32,
    parameter int SETTLE_CYCLES = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            halt_req,
    input  logic            sleep_req,
    input  logic            cfg_deep_halt,
    input  logic            int_en,
    input  logic            nmi,
    input  logic            ctm_irq,
    input  logic [NEXT-1:0] ext_irq,
    input  logic [NPER-1:0] per_irq,
    input  logic            per_clk_req,
    input  logic [AW-1:0]   next_pc,
    input  logic            lsc_tick,
    output logic            cpu_clk_en,
    output logic            bus_clk_en,
    output logic            hosc_en,
    output logic            per_clk_en,
    output logic            losc_en,
    output logic            ctm_en,
    output logic            trap_req,
    output logic [AW-1:0]   ret_addr,
    output logic [2:0]      stby_state
);

    stby_state_e st_q, st_d;
    logic        wake_halt, wake_sleep;
    logic        enter_sleep, enter_halt, capture;
    logic        settle_clr, settle_done;
    logic        trap_d;
    logic [AW-1:0] ret_q;

    stby_wake_qual #(.NEXT(NEXT), .NPER(NPER)) u_wake (
        .int_en     (int_en),
        .nmi        (nmi),
        .ctm_irq    (ctm_irq),
        .ext_irq    (ext_irq),
        .per_irq    (per_irq),
        .wake_halt  (wake_halt),
        .wake_sleep (wake_sleep)
    );

    // Entry acceptance: RUN only, sleep first, cancelled by a same-cycle wake.
    always_comb begin
        enter_sleep = (st_q == ST_RUN) && sleep_req && !wake_sleep;
        enter_halt  = (st_q == ST_RUN) && !sleep_req && halt_req && !wake_halt;
        capture     = enter_sleep || enter_halt;
    end

    // Next-state and trap decision.
    always_comb begin
        st_d       = st_q;
        trap_d     = 1'b0;
        settle_clr = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                if (enter_sleep)     st_d = ST_SLEEP;
                else if (enter_halt) st_d = cfg_deep_halt ? ST_HALT_DEEP : ST_HALT;
            end
            ST_HALT, ST_HALT_DEEP: begin
                if (wake_halt) begin
                    st_d   = ST_RUN;
                    trap_d = 1'b1;
                end
            end
            ST_SLEEP: begin
                if (wake_sleep) begin
                    st_d       = ST_SETTLE;
                    settle_clr = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (settle_done) begin
                    st_d   = ST_RUN;
                    trap_d = 1'b1;
                end
            end
            default: st_d = ST_RUN;
        endcase
    end

    // State and trap registers; reset beats every wake source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_RUN;
            trap_req <= 1'b0;
        end else begin
            st_q     <= st_d;
            trap_req <= trap_d;
        end
    end

    // Return address captured with the accepted strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_q <= '0;
        end else if (capture) begin
            ret_q <= next_pc;
        end
    end

    stby_settle_cnt #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (settle_clr),
        .en    (st_q == ST_SETTLE),
        .tick  (lsc_tick),
        .done  (settle_done)
    );

    stby_clk_dec u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .state       (st_q),
        .capture     (capture),
        .per_clk_req (per_clk_req),
        .cpu_clk_en  (cpu_clk_en),
        .bus_clk_en  (bus_clk_en),
        .hosc_en     (hosc_en),
        .per_clk_en  (per_clk_en),
        .losc_en     (losc_en),
        .ctm_en      (ctm_en)
    );

    // Drive the observable outputs.
    always_comb begin
        ret_addr   = ret_q;
        stby_state = st_q;
    end

    p_reset_wins_r11: assert property (@(posedge clk)
        !rst_n |=> (stby_state == 3'd0 && !trap_req));

    p_trap_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trap_req |=> !trap_req);

    p_ret_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_RUN) |=> $stable(ret_addr));

    p_halt_wake_trap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_halt(st_q) && wake_halt) |=> (trap_req && st_q == ST_RUN));

    p_sleep_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SLEEP && !nmi && !ctm_irq && ext_irq == '0) |=> st_q == ST_SLEEP);

    p_int_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_RUN && st_q != ST_SETTLE && !int_en && !nmi) |=> $stable(st_q));

    p_no_cross_entry_r12: assert property (@(posedge clk) disable iff (!rst_n)
        is_halt(st_q) |=> (st_q == ST_RUN || $stable(st_q)));

    p_settle_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SETTLE) |-> (hosc_en && !cpu_clk_en));

endmodule

// File: tb/stby_ctrl_test.sv
module stby_ctrl_test;

    localparam int NEXT = 4;
    localparam int NPER = 8;
    localparam int AW   = 32;
    localparam int SC   = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            halt_req = 1'b0, sleep_req = 1'b0, cfg_deep_halt = 1'b0;
    logic            int_en = 1'b1, nmi = 1'b0, ctm_irq = 1'b0;
    logic [NEXT-1:0] ext_irq = '0;
    logic [NPER-1:0] per_irq = '0;
    logic            per_clk_req = 1'b1;
    logic [AW-1:0]   next_pc = '0;
    logic            lsc_tick = 1'b0;
    logic            cpu_clk_en, bus_clk_en, hosc_en, per_clk_en, losc_en, ctm_en, trap_req;
    logic [AW-1:0]   ret_addr;
    logic [2:0]      stby_state;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    stby_ctrl #(.NEXT(NEXT), .NPER(NPER), .AW(AW), .SETTLE_CYCLES(SC)) uut (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .sleep_req(sleep_req),
        .cfg_deep_halt(cfg_deep_halt), .int_en(int_en), .nmi(nmi), .ctm_irq(ctm_irq),
        .ext_irq(ext_irq), .per_irq(per_irq), .per_clk_req(per_clk_req),
        .next_pc(next_pc), .lsc_tick(lsc_tick), .cpu_clk_en(cpu_clk_en),
        .bus_clk_en(bus_clk_en), .hosc_en(hosc_en), .per_clk_en(per_clk_en),
        .losc_en(losc_en), .ctm_en(ctm_en), .trap_req(trap_req),
        .ret_addr(ret_addr), .stby_state(stby_state)
    );

    // Bench model of the requirements.
    int          m_st = 0;
    bit          m_trap = 1'b0;
    bit          m_hold = 1'b1;
    int          m_cnt = 0;
    logic [AW-1:0] m_ret = '0;

    function automatic bit f_wake_halt();
        return nmi || (int_en && (ctm_irq || ext_irq != 0 || per_irq != 0));
    endfunction

    function automatic bit f_wake_sleep();
        return nmi || (int_en && (ctm_irq || ext_irq != 0));
    endfunction

    // Expected enables, packed {cpu,bus,hosc,per,losc,ctm}.
    function automatic logic [5:0] f_gates(input int st, input bit hold, input bit req);
        case (st)
            0: return {3'b111, req, 2'b11};
            1: return {3'b011, hold, 2'b11};
            2: return {3'b001, hold, 2'b11};
            4: return 6'b001011;
            default: return 6'b000011;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_trap = 1'b0; m_cnt = 0; m_hold = 1'b1; m_ret = '0;
        end else begin
            m_trap = 1'b0;
            case (m_st)
                0: begin
                    if (sleep_req) begin
                        if (!f_wake_sleep()) begin m_st = 3; m_ret = next_pc; m_hold = per_clk_req; end
                    end else if (halt_req && !f_wake_halt()) begin
                        m_st = cfg_deep_halt ? 2 : 1; m_ret = next_pc; m_hold = per_clk_req;
                    end
                end
                1, 2: if (f_wake_halt()) begin m_st = 0; m_trap = 1'b1; end
                3: if (f_wake_sleep()) begin m_st = 4; m_cnt = 0; end
                default: if (lsc_tick) begin
                    if (m_cnt == SC - 1) begin m_st = 0; m_trap = 1'b1; m_cnt = 0; end
                    else m_cnt = m_cnt + 1;
                end
            endcase
        end
    end

    function automatic string f_tag(input int st);
        case (st)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R5";
            default: return "R10";
        endcase
    endfunction

    // Cycle-by-cycle model comparison.
    always @(negedge clk) begin
        if (!finished) begin
            logic [5:0] g;
            g = f_gates(m_st, m_hold, per_clk_req);
            total++;
            if (stby_state != 3'(m_st)) begin
                bad++; $display("FAIL %s state act=%0d exp=%0d", f_tag(m_st), stby_state, m_st);
            end
            total++;
            if ({cpu_clk_en, bus_clk_en, hosc_en, per_clk_en, losc_en, ctm_en} !== g) begin
                bad++; $display("FAIL %s gates act=%b exp=%b", f_tag(m_st),
                    {cpu_clk_en, bus_clk_en, hosc_en, per_clk_en, losc_en, ctm_en}, g);
            end
            total++;
            if (trap_req !== m_trap || ret_addr !== m_ret) begin
                bad++; $display("FAIL R9 trap/ret act=%b/%h exp=%b/%h", trap_req, ret_addr, m_trap, m_ret);
            end
        end
    end

    task automatic step();
        @(posedge clk); @(negedge clk); #1;
    endtask

    task automatic chk(input string rq, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++; $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            bad++; $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        step(); step();
        // R1 reset state
        chk("R1 state", 32'(stby_state), 0);
        chk("R1 gates", 32'({cpu_clk_en, bus_clk_en, hosc_en, per_clk_en, losc_en, ctm_en}), 32'h3f);
        chk("R1 trap", 32'(trap_req), 0);
        rst_n = 1'b1; step();

        // R2 shallow halt, R4 hold, R6 external wake, R9 trap/ret
        next_pc = 32'h1234; halt_req = 1'b1; step(); halt_req = 1'b0;
        chk("R2 state", 32'(stby_state), 1);
        chk("R2 gates", 32'({cpu_clk_en, bus_clk_en, hosc_en}), 32'b011);
        per_clk_req = 1'b0; step();
        chk("R4 hold", 32'(per_clk_en), 1);
        ext_irq = 4'b0100; step(); ext_irq = '0;
        chk("R6 wake", 32'(stby_state), 0);
        chk("R9 trap", 32'(trap_req), 1);
        chk("R9 ret", ret_addr, 32'h1234);
        step();
        chk("R9 pulse", 32'(trap_req), 0);

        // R3 deep halt, R4 hold low, R6 peripheral wake
        cfg_deep_halt = 1'b1; halt_req = 1'b1; step(); halt_req = 1'b0; per_clk_req = 1'b1;
        chk("R3 gates", 32'({stby_state, cpu_clk_en, bus_clk_en, hosc_en}), {3'd2, 3'b001});
        step();
        chk("R4 hold low", 32'(per_clk_en), 0);
        per_irq = 8'h02; step(); per_irq = '0;
        chk("R6 per wake", 32'({stby_state, trap_req}), {3'd0, 1'b1});

        // R5 sleep, R7 per ignored, R12 strobes ignored, R10 settle
        next_pc = 32'h2000; sleep_req = 1'b1; step(); sleep_req = 1'b0;
        chk("R5 gates", 32'({cpu_clk_en, bus_clk_en, hosc_en, per_clk_en, losc_en, ctm_en}), 32'b000011);
        per_irq = '1; step(); per_irq = '0;
        chk("R7 per ignored", 32'(stby_state), 3);
        halt_req = 1'b1; next_pc = 32'h9999; step(); halt_req = 1'b0;
        chk("R12 strobe in sleep", 32'({stby_state, ret_addr[15:0]}), {3'd3, 16'h2000});
        ctm_irq = 1'b1; step(); ctm_irq = 1'b0;
        chk("R10 settle", 32'({stby_state, hosc_en, cpu_clk_en}), {3'd4, 2'b10});
        for (int i = 0; i < SC; i++) begin
            step();
            chk("R10 no tick", 32'(stby_state), 4);
            lsc_tick = 1'b1; step(); lsc_tick = 1'b0;
            if (i < SC - 1) chk("R10 counting", 32'(stby_state), 4);
            else chk("R10 release", 32'({stby_state, trap_req}), {3'd0, 1'b1});
        end
        chk("R9 sleep ret", ret_addr, 32'h2000);

        // R8 masked interrupts, NMI wakes
        int_en = 1'b0; cfg_deep_halt = 1'b0; halt_req = 1'b1; step(); halt_req = 1'b0;
        ext_irq = '1; ctm_irq = 1'b1; per_irq = '1; step();
        chk("R8 masked", 32'(stby_state), 1);
        nmi = 1'b1; step(); nmi = 1'b0; ext_irq = '0; ctm_irq = 1'b0; per_irq = '0;
        chk("R8 nmi", 32'({stby_state, trap_req}), {3'd0, 1'b1});
        int_en = 1'b1;

        // R12 cancel, sleep priority; R11 reset priority
        halt_req = 1'b1; ext_irq = 4'b0001; step(); halt_req = 1'b0; ext_irq = '0;
        chk("R12 cancel", 32'({stby_state, trap_req}), {3'd0, 1'b0});
        halt_req = 1'b1; sleep_req = 1'b1; per_irq = 8'h80; step();
        halt_req = 1'b0; sleep_req = 1'b0; per_irq = '0;
        chk("R12 sleep wins", 32'(stby_state), 3);
        rst_n = 1'b0; nmi = 1'b1; step(); nmi = 1'b0; rst_n = 1'b1;
        chk("R11 reset", 32'({stby_state, trap_req}), {3'd0, 1'b0});

        // Seeded random traffic against the model.
        for (int i = 0; i < 6000; i++) begin
            rst_n         = ($urandom % 500) != 0;
            halt_req      = ($urandom % 6) == 0;
            sleep_req     = ($urandom % 9) == 0;
            cfg_deep_halt = 1'($urandom);
            int_en        = ($urandom % 5) != 0;
            nmi           = ($urandom % 70) == 0;
            ctm_irq       = ($urandom % 45) == 0;
            ext_irq       = (($urandom % 35) == 0) ? NEXT'($urandom) : '0;
            per_irq       = (($urandom % 12) == 0) ? NPER'($urandom) : '0;
            per_clk_req   = 1'($urandom);
            next_pc       = $urandom;
            lsc_tick      = (i % 3) == 0;
            step();
        end

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule